// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point values: 1 sign bit in bit 31, an 8-bit exponent biased by 127 in bits 30:23, and a 23-bit fraction in bits 22:0 behind an implicit leading one. A caller presents both operands and an operation select, and pulses `start`. The block then steps through four stages, one clock each. First the smaller operand's significand is shifted right to match the larger exponent, with guard, round and sticky bits kept. Then the signed significands are summed. Then the sum is normalized back to the form 1.x and the exponent range is checked. Finally the result is rounded to nearest, ties to even, and renormalized. `done` pulses once the packed result is ready.

The controller has six states. IDLE waits. On `start` it captures the operands and goes to ALIGN, then ADD, then NORM, then ROUND, then DONE. From DONE it returns to IDLE, or it goes straight to ALIGN if `start` is high in that cycle. The path ALIGN→ADD→NORM→ROUND→DONE is unconditional. Operands whose exponent code is 0 are treated as zero. Operands whose exponent code is 255 (infinity or NaN) bypass the arithmetic.

Top module: `flt_addsub_seq`

## Requirements
- R1: With `op_sub`=0 and two normal operands, `sum_out` is the correctly rounded sum, with the sign of the larger-magnitude operand.
- R2: With `op_sub`=1, the result equals the sum of `opnd_a` and `opnd_b` with bit 31 of `opnd_b` inverted.
- R3: Rounding is to nearest with ties to even, using guard, round and sticky bits from alignment. A carry out of rounding increments the exponent and leaves the fraction zero.
- R4: If the final exponent reaches 255, `sum_out` is a signed infinity (exponent 255, fraction 0) and `ovf` is 1.
- R5: If the normalized exponent is below 1, `sum_out` is a signed zero (bits 30:0 zero) and `unf` is 1.
- R6: An exactly zero sum yields +0 (all 32 bits zero) with both flags 0.
- R7: An operand with exponent code 0 is treated as zero, whatever its fraction.
- R8: If `opnd_a` has exponent 255, `sum_out` equals `opnd_a`. Otherwise, if the effective second operand has exponent 255, `sum_out` equals that operand (sign inverted when subtracting). Both flags are 0 in these cases.
- R9: `done` is high for exactly one cycle, 5 clock edges after an accepted `start`. `sum_out`, `ovf` and `unf` change only in a cycle where `done` is high and hold their values until then.
- R10: `start` is accepted only in IDLE or DONE. A `start` in any other state has no effect on the result or on the timing.
- R11: After reset `sum_out`, `ovf`, `unf` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled in IDLE or DONE) |
| op_sub | input | 1 | 1 selects subtraction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sum_out | output | 32 | Packed result |
| ovf | output | 1 | Result overflowed to infinity |
| unf | output | 1 | Result fell below the normal range |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
The bound checker watches the protocol on every cycle. It checks that `done` is a single-cycle pulse that arrives exactly five edges after an accepted `start`, and that the outputs move only with `done`. It also checks that the two flags never rise together, that `ovf` always comes with an infinity code, and that `unf` always comes with a zero magnitude. Whether the numbers are right cannot be shown cycle by cycle. The bench's vectors cover that: exact sums, cancellation, ties broken both ways, rounding carry, sticky-only tails, flush of tiny operands, special-value bypass, and a `start` dropped while the block is busy.

// File: rtl/fas_pkg.sv
package fas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_ROUND,
        ST_DONE
    } fas_state_t;
endpackage

// File: rtl/fas_align.sv
// Right shift that folds every bit shifted out into the lowest (sticky) bit.
module fas_align #(
    parameter int W   = 27,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   dout
);
    logic [W-1:0] shifted;
    logic [W-1:0] mask;
    logic         lost;

    always_comb begin
        shifted = din >> shamt;
        mask    = ~({W{1'b1}} << shamt);
        lost    = |(din & mask);
        dout    = {shifted[W-1:1], shifted[0] | lost};
    end
endmodule

// File: rtl/fas_lzc.sv
// Leading-zero count; returns W for an all-zero input.
module fas_lzc #(
    parameter int W  = 27,
    parameter int CW = 5
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fas_round.sv
// Nearest-even increment decision and significand increment.
module fas_round #(
    parameter int MW = 24
) (
    input  logic [MW-1:0] mant,
    input  logic          g,
    input  logic          r,
    input  logic          s,
    output logic [MW-1:0] mant_out,
    output logic          cout
);
    logic inc;

    assign inc              = g & (r | s | mant[0]);
    assign {cout, mant_out} = {1'b0, mant} + {{MW{1'b0}}, inc};
endmodule

// File: rtl/flt_addsub_seq.sv
module flt_addsub_seq
    import fas_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int DW     = 1 + EXP_W + FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_sub,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] sum_out,
    output logic          ovf,
    output logic          unf,
    output logic          done
);
    localparam int SIG_W = FRAC_W + 1;          // with hidden bit
    localparam int XW    = SIG_W + 3;           // plus guard, round, sticky
    localparam int SW    = XW + 1;              // plus carry
    localparam int EW    = EXP_W + 2;           // signed working exponent
    localparam int SHW   = $clog2(XW + 1);
    localparam int EMAX  = (1 << EXP_W) - 1;
    localparam logic signed [EW-1:0] EMAX_S = EW'(EMAX);

    fas_state_t state, state_nx;
    logic       accept;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: state_nx = start ? ST_ALIGN : ST_IDLE;
            ST_ALIGN:         state_nx = ST_ADD;
            ST_ADD:           state_nx = ST_NORM;
            ST_NORM:          state_nx = ST_ROUND;
            ST_ROUND:         state_nx = ST_DONE;
            default:          state_nx = ST_IDLE;
        endcase
    end

    assign accept = (state == ST_IDLE) || (state == ST_DONE);

    // ---------------- captured operands ----------------
    logic [DW-1:0] a_q, b_q;

    // ---------------- ALIGN stage logic ----------------
    logic               sa, sb, a_spec, b_spec, swap;
    logic [EXP_W-1:0]   ea, eb, big_e, sml_e, ediff;
    logic [SIG_W-1:0]   ma, mb, big_m, sml_m;
    logic               big_s, sml_s;
    logic [SHW-1:0]     shamt;
    logic [XW-1:0]      sml_x;

    always_comb begin
        sa     = a_q[DW-1];
        sb     = b_q[DW-1];
        ea     = a_q[DW-2:FRAC_W];
        eb     = b_q[DW-2:FRAC_W];
        a_spec = &ea;
        b_spec = &eb;
        ma     = (ea == '0) ? '0 : {1'b1, a_q[FRAC_W-1:0]};
        mb     = (eb == '0) ? '0 : {1'b1, b_q[FRAC_W-1:0]};
        swap   = eb > ea;
        big_e  = swap ? eb : ea;
        sml_e  = swap ? ea : eb;
        big_m  = swap ? mb : ma;
        sml_m  = swap ? ma : mb;
        big_s  = swap ? sb : sa;
        sml_s  = swap ? sa : sb;
        ediff  = big_e - sml_e;
        shamt  = (32'(ediff) > XW) ? SHW'(XW) : ediff[SHW-1:0];
    end

    fas_align #(.W(XW), .SHW(SHW)) u_align (
        .din   ({sml_m, 3'b000}),
        .shamt (shamt),
        .dout  (sml_x)
    );

    logic [XW-1:0]    xa_q, xb_q;
    logic             sa_q, sb_q, spec_q;
    logic [EXP_W-1:0] e_q;
    logic [DW-1:0]    spec_v_q;

    // ---------------- ADD stage logic ----------------
    logic [SW-1:0] sum_c, sum_q;
    logic          sgn_c, sgn_q;

    always_comb begin
        if (sa_q == sb_q) begin
            sum_c = {1'b0, xa_q} + {1'b0, xb_q};
            sgn_c = sa_q;
        end else if (xa_q >= xb_q) begin
            sum_c = {1'b0, xa_q - xb_q};
            sgn_c = sa_q;
        end else begin
            sum_c = {1'b0, xb_q - xa_q};
            sgn_c = sb_q;
        end
    end

    // ---------------- NORM stage logic ----------------
    logic [SHW-1:0]       lz;
    logic [XW-1:0]        norm_c, norm_q;
    logic signed [EW-1:0] nexp_c, nexp_q;
    logic                 zero_q;

    fas_lzc #(.W(XW), .CW(SHW)) u_lzc (
        .din (sum_q[XW-1:0]),
        .cnt (lz)
    );

    always_comb begin
        if (sum_q[SW-1]) begin
            norm_c = {sum_q[SW-1:2], |sum_q[1:0]};
            nexp_c = $signed({2'b00, e_q}) + EW'(1);
        end else begin
            norm_c = sum_q[XW-1:0] << lz;
            nexp_c = $signed({2'b00, e_q}) - $signed(EW'(lz));
        end
    end

    // ---------------- ROUND stage logic ----------------
    logic [SIG_W-1:0]     rm;
    logic                 rc;
    logic signed [EW-1:0] fexp;
    logic [DW-1:0]        res_c;
    logic                 ovf_c, unf_c;

    fas_round #(.MW(SIG_W)) u_round (
        .mant     (norm_q[XW-1:3]),
        .g        (norm_q[2]),
        .r        (norm_q[1]),
        .s        (norm_q[0]),
        .mant_out (rm),
        .cout     (rc)
    );

    always_comb begin
        fexp  = nexp_q + $signed({{(EW-1){1'b0}}, rc});
        ovf_c = 1'b0;
        unf_c = 1'b0;
        if (spec_q) begin
            res_c = spec_v_q;
        end else if (zero_q) begin
            res_c = '0;
        end else if (nexp_q < 1) begin
            res_c = {sgn_q, {(DW-1){1'b0}}};
            unf_c = 1'b1;
        end else if (fexp >= EMAX_S) begin
            res_c = {sgn_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_c = 1'b1;
        end else begin
            res_c = {sgn_q, fexp[EXP_W-1:0], rc ? {FRAC_W{1'b0}} : rm[FRAC_W-1:0]};
        end
    end

    // ---------------- stage registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            xa_q     <= '0;
            xb_q     <= '0;
            sa_q     <= 1'b0;
            sb_q     <= 1'b0;
            e_q      <= '0;
            spec_q   <= 1'b0;
            spec_v_q <= '0;
            sum_q    <= '0;
            sgn_q    <= 1'b0;
            norm_q   <= '0;
            nexp_q   <= '0;
            zero_q   <= 1'b0;
        end else begin
            if (accept && start) begin
                a_q <= opnd_a;
                b_q <= {opnd_b[DW-1] ^ op_sub, opnd_b[DW-2:0]};
            end
            if (state == ST_ALIGN) begin
                xa_q     <= {big_m, 3'b000};
                xb_q     <= sml_x;
                sa_q     <= big_s;
                sb_q     <= sml_s;
                e_q      <= big_e;
                spec_q   <= a_spec | b_spec;
                spec_v_q <= a_spec ? a_q : b_q;
            end
            if (state == ST_ADD) begin
                sum_q <= sum_c;
                sgn_q <= sgn_c;
            end
            if (state == ST_NORM) begin
                norm_q <= norm_c;
                nexp_q <= nexp_c;
                zero_q <= (sum_q == '0);
            end
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_out <= '0;
            ovf     <= 1'b0;
            unf     <= 1'b0;
        end else if (state == ST_ROUND) begin
            sum_out <= res_c;
            ovf     <= ovf_c;
            unf     <= unf_c;
        end
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/fas_chk.sv
module fas_chk #(
    parameter int DW     = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          accept,
    input logic          done,
    input logic          ovf,
    input logic          unf,
    input logic [DW-1:0] sum_out
);
    logic [2:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                lat_cnt <= 3'd0;
        else if (accept && start)                  lat_cnt <= 3'd1;
        else if (lat_cnt == 3'd5)                  lat_cnt <= 3'd0;
        else if (lat_cnt != 3'd0)                  lat_cnt <= lat_cnt + 3'd1;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == 3'd5));

    // R10
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == 3'd5) |-> done);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sum_out, ovf, unf}) |-> done);

    // R4
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (sum_out[DW-2:FRAC_W] == {EXP_W{1'b1}} && sum_out[FRAC_W-1:0] == '0));

    // R5
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (sum_out[DW-2:0] == '0));

    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));
endmodule

bind flt_addsub_seq fas_chk #(.DW(DW), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .done    (done),
    .ovf     (ovf),
    .unf     (unf),
    .sum_out (sum_out)
);

// File: tb/flt_addsub_seq_bench.sv
module flt_addsub_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] sum_out;
    logic        ovf, unf, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    flt_addsub_seq u_flt_addsub_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sum_out(sum_out),
        .ovf(ovf), .unf(unf), .done(done)
    );

    // {a, b, sub, expected result, ovf, unf}
    localparam int NV = 20;
    localparam logic [98:0] VEC [NV] = '{
        {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0}, // R1 1+1
        {32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000, 1'b0, 1'b0}, // R1 cancel
        {32'h3FC00000, 32'h40100000, 1'b0, 32'h40700000, 1'b0, 1'b0}, // R1 1.5+2.25
        {32'h3F800000, 32'hC0400000, 1'b0, 32'hC0000000, 1'b0, 1'b0}, // R1 larger negative
        {32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0}, // R2 3-1
        {32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0}, // R6 1-1
        {32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R6 -1+1
        {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R3 tie, even down
        {32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0}, // R3 tie, odd up
        {32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0}, // R3 above half
        {32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0}, // R3 round carry
        {32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0, 1'b0}, // R3 sticky borrow
        {32'h3F800001, 32'h30800000, 1'b0, 32'h3F800001, 1'b0, 1'b0}, // R3 sticky only
        {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0}, // R4 +inf
        {32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1, 1'b0}, // R4 -inf
        {32'h00800000, 32'h00C00000, 1'b1, 32'h80000000, 1'b0, 1'b1}, // R5 -0
        {32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R7 tiny ignored
        {32'h00000001, 32'h00000002, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R7 both tiny
        {32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0}, // R8 NaN a
        {32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0}  // R8 inf b negated
    };
    localparam string TAG [NV] = '{
        "R1", "R1", "R1", "R1", "R2", "R6", "R6", "R3", "R3", "R3",
        "R3", "R3", "R3", "R4", "R4", "R5", "R7", "R7", "R8", "R8"
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          output int lat);
        opnd_a = a;
        opnd_b = b;
        op_sub = s;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        lat    = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [31:0] held;
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11", "reset sum_out", sum_out, 32'h0);
        check("R11", "reset flags/done", {29'd0, ovf, unf, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][98:67], VEC[i][66:35], VEC[i][34], lat);
            check(TAG[i], $sformatf("vector %0d result", i), sum_out, VEC[i][33:2]);
            check(TAG[i], $sformatf("vector %0d flags", i), {30'd0, ovf, unf},
                  {30'd0, VEC[i][1], VEC[i][0]});
            check("R9", $sformatf("vector %0d latency", i), 32'(lat), 32'd5);
            @(negedge clk);
            check("R9", "done single pulse", {31'd0, done}, 32'd0);
        end

        // R9: result holds while idle
        held = sum_out;
        repeat (10) @(negedge clk);
        check("R9", "result held", sum_out, held);

        // R10: start while busy is ignored
        opnd_a = 32'h3F800000; opnd_b = 32'h3F800000; op_sub = 1'b0;
        start = 1'b1;
        @(negedge clk);
        opnd_a = 32'h40400000; opnd_b = 32'h40400000; op_sub = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R10", "busy start ignored result", sum_out, 32'h40000000);
        check("R10", "busy start latency", 32'(lat), 32'd5);
        @(negedge clk);
        check("R10", "no second done", {31'd0, done}, 32'd0);
        repeat (6) @(negedge clk);
        check("R10", "still no done", {31'd0, done}, 32'd0);

        // R9: back-to-back start accepted in the done cycle
        run_op(32'h3F800000, 32'h3F800000, 1'b0, lat);
        opnd_a = 32'h40400000; opnd_b = 32'h3F800000; op_sub = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R9", "back-to-back result", sum_out, 32'h40000000);
        check("R9", "back-to-back latency", 32'(lat), 32'd5);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule